// File: doc/BRIEF.md
# Line Status Flag Logic

This block produces the three upper flags of a UART line status byte: the holding-empty flag, the transmitter-empty flag and the receive error summary flag. The transmit side reports write strobes into the holding register or transmit FIFO, an indication that the holding stage is empty, and an indication that the shift register is empty. From these the block keeps the two empty flags that software polls before loading the next character.

The receive side reports each entry pushed into and popped from the receive FIFO, together with a 3-bit error tag for the pushed entry. The block keeps its own copy of these tags and a count of the errored entries still queued. From that count it drives the summary flag. The summary flag is held at zero when the port runs in plain single-character mode. In FIFO mode it is set while any errored entry is queued. It stays set until a status read happens at a time when no errored entry remains. All flags are registered and reset synchronously.

Top module: `lsr_flag_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `thre` and `temt` become 1, `rx_err_any` becomes 0 and the tag queue becomes empty.
- R2: A cycle with `thr_wr` high makes `thre` 0 in the next cycle. This holds even when `thr_empty` rises in the same cycle.
- R3: `thre` becomes 1 in the cycle after `thr_empty` goes from 0 to 1, with no write in that cycle. If `thr_empty` stays high without a new rise, it never sets `thre` again after a write has cleared it. The previous value of `thr_empty` resets to 1.
- R4: `temt` is registered and equals 1 exactly when the next value of `thre` is 1 and `tsr_empty` is 1. A write therefore clears `temt` in the next cycle.
- R5: When `fifo_mode` is 0, `rx_err_any` is 0 in the next cycle and the tag queue is flushed. Pushes made in that mode are discarded, so after a return to FIFO mode they never raise the flag.
- R6: In FIFO mode, pushing an entry with a nonzero tag sets `rx_err_any` in the next cycle. Tag bit 0 is parity, bit 1 is framing and bit 2 is break. A tag of 0 is a clean entry.
- R7: A status read (`lsr_rd`) while errored entries remain queued, after that cycle's push and pop, leaves `rx_err_any` at 1.
- R8: `rx_err_any` stays 1 after the last errored entry is popped and clears on the first read at which no errored entry remains. A read in the same cycle as the pop of the last errored entry clears it.
- R9: A pop while the queue is empty is ignored. A push while 16 entries are queued and no pop happens is ignored. A push and a pop together on a full queue both take effect.
- R10: A push and a pop in the same cycle update the errored-entry count by the pushed tag and the popped head tag together, in first-in first-out order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| fifo_mode | input | 1 | 1 = FIFO mode, 0 = plain single-character mode |
| thr_wr | input | 1 | Host wrote a byte into the holding register or transmit FIFO |
| thr_empty | input | 1 | Holding register or transmit FIFO is empty |
| tsr_empty | input | 1 | Transmit shift register is empty |
| rx_push | input | 1 | An entry enters the receive FIFO |
| rx_push_tag | input | 3 | Error tag of the entering entry (bit 0 parity, bit 1 framing, bit 2 break) |
| rx_pop | input | 1 | The head entry leaves the receive FIFO |
| lsr_rd | input | 1 | Host read of the line status byte |
| thre | output | 1 | Holding-empty flag (status bit 5) |
| temt | output | 1 | Transmitter-empty flag (status bit 6) |
| rx_err_any | output | 1 | Receive error summary flag (status bit 7) |

## Verification
The bench targets a read that coincides with the pop of the last errored entry. A design that samples the old count there would keep the flag stuck for one more read. It drives a write in the same cycle as a rise of `thr_empty`; a design with the wrong priority would report the holding stage empty while a byte sits in it. It fills the queue to 16 entries and then offers an errored push with and without a pop. A wrong full check would lose the error or corrupt the count. Errored pushes made in plain mode, followed by a switch to FIFO mode, expose a design that forgets to flush. The run then ends with a long stretch of random traffic compared against a queue-based model on every clock.

// File: rtl/lsr_flag_pkg.sv
package lsr_flag_pkg;
  localparam int unsigned RX_DEPTH = 16;
  localparam int unsigned TAG_W    = 3;

  localparam int unsigned TAG_PARITY  = 0;
  localparam int unsigned TAG_FRAMING = 1;
  localparam int unsigned TAG_BREAK   = 2;

  typedef logic [TAG_W-1:0] err_tag_t;

  function automatic logic tag_is_errored(input err_tag_t t);
    return t[TAG_PARITY] | t[TAG_FRAMING] | t[TAG_BREAK];
  endfunction
endpackage

// File: rtl/lsr_tx_flags.sv
module lsr_tx_flags (
  input  logic clk,
  input  logic rst,
  input  logic thr_wr,
  input  logic thr_empty,
  input  logic tsr_empty,
  output logic thre,
  output logic temt
);
  logic empty_prev_q;
  logic empty_rise;
  logic thre_d;

  assign empty_rise = thr_empty & ~empty_prev_q;

  always_comb begin
    thre_d = thre;
    if (thr_wr)          thre_d = 1'b0;
    else if (empty_rise) thre_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_prev_q <= 1'b1;
      thre         <= 1'b1;
      temt         <= 1'b1;
    end else begin
      empty_prev_q <= thr_empty;
      thre         <= thre_d;
      temt         <= thre_d & tsr_empty;
    end
  end

  // R2: a write always leaves the holding stage occupied next cycle
  a_r2_write_clears: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !thre);
  // R4: a write also clears the transmitter-empty flag
  a_r4_write_clears_temt: assert property (@(posedge clk) disable iff (rst)
    thr_wr |=> !temt);
  // R4: transmitter-empty only rises while the shift register is empty
  a_r4_temt_needs_tsr: assert property (@(posedge clk) disable iff (rst)
    !tsr_empty |=> !temt);
  // R3: holding-empty never rises without an empty indication
  a_r3_rise_needs_empty: assert property (@(posedge clk) disable iff (rst)
    (!thre && !thr_empty) |=> !thre);
endmodule

// File: rtl/lsr_tag_queue.sv
module lsr_tag_queue
  import lsr_flag_pkg::*;
#(
  parameter int unsigned DEPTH = RX_DEPTH,
  parameter int unsigned TW    = TAG_W
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           enable,
  input  logic                           push,
  input  logic [TW-1:0]                  push_tag,
  input  logic                           pop,
  output logic [$clog2(DEPTH+1)-1:0]     err_cnt_q,
  output logic [$clog2(DEPTH+1)-1:0]     err_cnt_d
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH+1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH-1);

  logic [TW-1:0] tag_mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] occ_q;
  logic          pop_ok, push_ok;
  logic          head_err, push_err;

  assign pop_ok   = enable & pop & (occ_q != '0);
  assign push_ok  = enable & push & ((occ_q != FULL_CNT) | pop_ok);
  assign head_err = |tag_mem[rd_ptr];
  assign push_err = |push_tag;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    if (!enable) begin
      err_cnt_d = '0;
    end else begin
      err_cnt_d = err_cnt_q;
      if (push_ok && push_err)  err_cnt_d = err_cnt_d + 1'b1;
      if (pop_ok  && head_err)  err_cnt_d = err_cnt_d - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) tag_mem[wr_ptr] <= push_tag;
  end

  always_ff @(posedge clk) begin
    if (rst || !enable) begin
      wr_ptr    <= '0;
      rd_ptr    <= '0;
      occ_q     <= '0;
      err_cnt_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   occ_q <= occ_q + 1'b1;
        2'b01:   occ_q <= occ_q - 1'b1;
        default: occ_q <= occ_q;
      endcase
      err_cnt_q <= err_cnt_d;
    end
  end

  // R9: occupancy never passes the queue depth
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    occ_q <= FULL_CNT);
  // R9: a pop on an empty queue leaves it empty
  a_r9_pop_empty: assert property (@(posedge clk) disable iff (rst)
    (occ_q == '0 && !push) |=> occ_q == '0);
  // R10: errored entries are a subset of queued entries
  a_r10_err_le_occ: assert property (@(posedge clk) disable iff (rst)
    err_cnt_q <= occ_q);
  // R5: plain mode flushes the queue
  a_r5_flush: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (occ_q == '0 && err_cnt_q == '0));
endmodule

// File: rtl/lsr_err_summary.sv
module lsr_err_summary #(
  parameter int unsigned CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic          lsr_rd,
  input  logic [CW-1:0] err_cnt_d,
  input  logic [CW-1:0] err_cnt_q,
  output logic          err_flag
);
  logic pending;
  logic keep;

  assign pending = (err_cnt_d != '0);
  assign keep    = err_flag & ~lsr_rd;

  always_ff @(posedge clk) begin
    if (rst) err_flag <= 1'b0;
    else     err_flag <= fifo_mode & (pending | keep);
  end

  // R5: plain mode forces the summary to zero
  a_r5_plain_zero: assert property (@(posedge clk) disable iff (rst)
    !fifo_mode |=> !err_flag);
  // R6: the summary only rises once the queue holds an errored entry
  a_r6_rise_has_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> (err_cnt_q != '0));
  // R7: a read does not clear while errored entries remain
  a_r7_read_keeps: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && err_flag && err_cnt_d != '0) |=> err_flag);
  // R8: without a read the summary is sticky in FIFO mode
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (fifo_mode && err_flag && !lsr_rd) |=> err_flag);
endmodule

// File: rtl/lsr_flag_unit.sv
module lsr_flag_unit
  import lsr_flag_pkg::*;
#(
  parameter int unsigned DEPTH = RX_DEPTH,
  parameter int unsigned TW    = TAG_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          fifo_mode,
  input  logic          thr_wr,
  input  logic          thr_empty,
  input  logic          tsr_empty,
  input  logic          rx_push,
  input  logic [TW-1:0] rx_push_tag,
  input  logic          rx_pop,
  input  logic          lsr_rd,
  output logic          thre,
  output logic          temt,
  output logic          rx_err_any
);
  localparam int unsigned CW = $clog2(DEPTH+1);

  logic [CW-1:0] err_cnt_q;
  logic [CW-1:0] err_cnt_d;

  lsr_tx_flags tx_i (
    .clk       (clk),
    .rst       (rst),
    .thr_wr    (thr_wr),
    .thr_empty (thr_empty),
    .tsr_empty (tsr_empty),
    .thre      (thre),
    .temt      (temt)
  );

  lsr_tag_queue #(.DEPTH(DEPTH), .TW(TW)) queue_i (
    .clk       (clk),
    .rst       (rst),
    .enable    (fifo_mode),
    .push      (rx_push),
    .push_tag  (rx_push_tag),
    .pop       (rx_pop),
    .err_cnt_q (err_cnt_q),
    .err_cnt_d (err_cnt_d)
  );

  lsr_err_summary #(.CW(CW)) sum_i (
    .clk       (clk),
    .rst       (rst),
    .fifo_mode (fifo_mode),
    .lsr_rd    (lsr_rd),
    .err_cnt_d (err_cnt_d),
    .err_cnt_q (err_cnt_q),
    .err_flag  (rx_err_any)
  );

  // R1: leaving reset the flags show an idle transmitter and no errors
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (thre && temt && !rx_err_any));
endmodule

// File: tb/lsr_flag_unit_tb_top.sv
module lsr_flag_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifo_mode = 1'b1, thr_wr = 1'b0, thr_empty = 1'b1, tsr_empty = 1'b1;
  logic rx_push = 1'b0, rx_pop = 1'b0, lsr_rd = 1'b0;
  logic [2:0] rx_push_tag = 3'd0;
  logic thre, temt, rx_err_any;

  always #10 clk = ~clk;

  lsr_flag_unit dut_i (
    .clk(clk), .rst(rst), .fifo_mode(fifo_mode), .thr_wr(thr_wr),
    .thr_empty(thr_empty), .tsr_empty(tsr_empty), .rx_push(rx_push),
    .rx_push_tag(rx_push_tag), .rx_pop(rx_pop), .lsr_rd(lsr_rd),
    .thre(thre), .temt(temt), .rx_err_any(rx_err_any)
  );

  int errors = 0, checks = 0;
  string phase = "R1";
  bit started = 0, done = 0;

  // behavioural model
  bit m_thre = 1, m_temt = 1, m_err = 0, m_prev = 1;
  int q[$];

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      m_thre = 1; m_temt = 1; m_err = 0; m_prev = 1; q.delete();
    end else begin
      bit rise, pop_ok, push_ok;
      int nerr;
      rise = thr_empty && !m_prev;
      m_prev = thr_empty;
      if (thr_wr) m_thre = 0; else if (rise) m_thre = 1;
      m_temt = m_thre && tsr_empty;
      if (!fifo_mode) q.delete();
      else begin
        pop_ok = rx_pop && q.size() > 0;
        push_ok = rx_push && (q.size() < 16 || pop_ok);
        if (pop_ok) void'(q.pop_front());
        if (push_ok) q.push_back(int'(rx_push_tag));
      end
      nerr = 0;
      foreach (q[i]) if (q[i] != 0) nerr++;
      m_err = fifo_mode && (nerr > 0 || (m_err && !lsr_rd));
    end
  end

  task automatic chk(input string req, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (started && !done) begin
    chk({phase, " thre"}, thre, m_thre);
    chk({phase, " temt"}, temt, m_temt);
    chk({phase, " rx_err_any"}, rx_err_any, m_err);
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic idle();
    thr_wr = 0; rx_push = 0; rx_pop = 0; lsr_rd = 0; rx_push_tag = 0;
  endtask
  task automatic push(input logic [2:0] t);
    rx_push = 1; rx_push_tag = t; tick(); idle();
  endtask
  task automatic pop1(); rx_pop = 1; tick(); idle(); endtask
  task automatic rd(); lsr_rd = 1; tick(); idle(); endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    // R1 explicit reset state
    chk("R1 thre", thre, 1'b1);
    chk("R1 temt", temt, 1'b1);
    chk("R1 rx_err_any", rx_err_any, 1'b0);
    rst = 0; tick();

    phase = "R2"; tsr_empty = 0; thr_wr = 1; tick(); idle();
    chk("R2 thre after write", thre, 1'b0);
    phase = "R3"; tick();
    chk("R3 no set without rise", thre, 1'b0);
    thr_empty = 0; tick(); thr_empty = 1; tick();
    chk("R3 set on rise", thre, 1'b1);
    chk("R4 temt with busy shifter", temt, 1'b0);
    phase = "R4"; tsr_empty = 1; tick();
    chk("R4 temt both empty", temt, 1'b1);
    phase = "R2"; thr_empty = 0; tick(); thr_empty = 1; thr_wr = 1; tick(); idle();
    chk("R2 write beats rise", thre, 1'b0);
    chk("R4 write clears temt", temt, 1'b0);
    thr_empty = 0; tick(); thr_empty = 1; tick();

    phase = "R5"; fifo_mode = 0; push(3'b001); push(3'b100); rd();
    chk("R5 plain mode zero", rx_err_any, 1'b0);
    fifo_mode = 1; tick(); tick();
    chk("R5 discarded pushes", rx_err_any, 1'b0);

    phase = "R6"; push(3'b000);
    chk("R6 clean entry", rx_err_any, 1'b0);
    push(3'b001);
    chk("R6 parity sets", rx_err_any, 1'b1);
    push(3'b010); push(3'b100);
    phase = "R7"; pop1(); rd();
    chk("R7 read keeps", rx_err_any, 1'b1);
    pop1(); pop1(); tick();
    phase = "R8"; rx_pop = 1; tick(); idle();
    chk("R8 sticky after last pop", rx_err_any, 1'b1);
    rd();
    chk("R8 read clears", rx_err_any, 1'b0);
    push(3'b010); rx_pop = 1; lsr_rd = 1; tick(); idle();
    chk("R8 read with last pop clears", rx_err_any, 1'b0);

    phase = "R9"; pop1(); pop1();
    for (int i = 0; i < 16; i++) push(3'b000);
    push(3'b100);
    chk("R9 full push ignored", rx_err_any, 1'b0);
    phase = "R10"; rx_push = 1; rx_push_tag = 3'b100; rx_pop = 1; tick(); idle();
    chk("R10 full push with pop", rx_err_any, 1'b1);
    rd();
    for (int i = 0; i < 15; i++) pop1();
    chk("R10 fifo order", rx_err_any, 1'b1);
    pop1(); rd();
    chk("R9 drained", rx_err_any, 1'b0);

    phase = "R10 random";
    for (int i = 0; i < 3000; i++) begin
      thr_wr = ($urandom % 6) == 0;
      thr_empty = ($urandom % 3) != 0;
      tsr_empty = ($urandom % 3) != 0;
      rx_push = ($urandom % 2) == 0;
      rx_push_tag = (($urandom % 4) == 0) ? 3'($urandom) : 3'd0;
      rx_pop = ($urandom % 2) == 0;
      lsr_rd = ($urandom % 4) == 0;
      fifo_mode = ($urandom % 40) != 0;
      tick();
    end
    idle(); fifo_mode = 1; tick();
    finish_run();
  end
endmodule